// File: doc/BRIEF.md
# Gated Multi-Mode Timer/Counter

This block is a byte-wide timer/counter. One pair of count registers, a low byte and a high byte, is read in one of three ways. It can be a 13-bit counter that uses the five lowest bits of the low byte under the high byte. It can be a 16-bit counter. It can also be an 8-bit counter in the low byte that reloads from the high byte. Each count step comes from one of three sources: every system clock, a prescaled tick strobe, or a falling edge on an external count pin.

Counting is allowed only while the run bit is set. Optionally, an external gate pin must also be at its active level, and that level is chosen by a polarity bit. When the counter wraps, it raises a sticky overflow flag. The flag produces an interrupt request when interrupts are enabled. Software or an interrupt acknowledge clears the flag.

Software reaches the block through a simple register port. A write is a single-cycle strobe with an address and a data byte. A read is a combinational lookup by address. This port carries no stream data, so it has no valid/ready handshake and no back-pressure: a write strobe is always accepted in the cycle it is presented. The tick, pin, gate and acknowledge inputs are plain level or strobe signals.

Top module: `gated_timer`

## Requirements
- R1: After reset, all four registers read 0, and `ovf_flag` and `irq` are 0.
- R2: Mode 1 (config bits [1:0] = 1) uses `{high, low}` as a 16-bit counter. Mode value 3 behaves the same way. A step from 0xFFFF gives 0x0000 and sets the overflow flag.
- R3: Mode 0 (config bits [1:0] = 0) counts `{high, low[4:0]}` as a 13-bit value. It carries from low bit 4 into the high byte, and it leaves low bits [7:5] unchanged. A step from 0x1FFF gives 0 and sets the flag.
- R4: Mode 2 (config bits [1:0] = 2) counts in the low byte only. A step from 0xFF loads the low byte from the high byte and sets the flag. The high byte never changes by counting.
- R5: With config bit 3 = 1 and bit 2 = 0, one step is taken in each cycle in which `tick_pre` is high. With both bits 0, one step is taken every clock.
- R6: With config bit 2 = 1, `cnt_pin` passes through a two-flop synchronizer, and one step is taken for each falling edge detected. The internal clock and the ticks then have no effect.
- R7: While the run bit (control bit 0) is 0, the count registers do not change except by register writes.
- R8: With gate enable (config bit 4) = 1, steps are taken only while the synchronized `gate_pin` XOR the invert bit (config bit 5) is 1. The config register reads back as written.
- R9: `irq` is high exactly when the overflow flag (control bit 2) and interrupt enable (control bit 1) are both 1.
- R10: The flag is cleared by a control write with bit 2 = 0 or by `irq_ack`. An overflow in the same cycle as a clear leaves the flag set. A control write with bit 2 = 1 leaves the flag as it is.
- R11: A write to the low byte (address 0) or the high byte (address 1) takes effect at the next edge and suppresses the count step in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low, 1 high, 2 config, 3 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as for writes |
| rd_data | output | 8 | Combinational read data |
| tick_pre | input | 1 | Prescaled time-base strobe |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| gate_pin | input | 1 | External gate pin (asynchronous) |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- while idle, the count stays unchanged;
- mode 0 never touches the upper low-byte bits;
- mode 2 never alters the reload byte;
- external mode steps only on a detected falling edge;
- an overflow always leaves the flag set in the next cycle, and an acknowledge clears it;
- the request never rises without the flag.

The exact count values need the bench's scenarios to show them. These cover the 13-bit carry and wrap, the 16-bit wrap, the reload value after an 8-bit wrap, tick and pin counting, both gate polarities, and a byte write that overrides a running count.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

  localparam int AW = 2;

  localparam logic [AW-1:0] A_LO  = 2'd0;
  localparam logic [AW-1:0] A_HI  = 2'd1;
  localparam logic [AW-1:0] A_CFG = 2'd2;
  localparam logic [AW-1:0] A_CTL = 2'd3;

  localparam int CTL_RUN  = 0;
  localparam int CTL_IEN  = 1;
  localparam int CTL_FLAG = 2;

  typedef enum logic [1:0] {
    MODE_13  = 2'd0,
    MODE_16  = 2'd1,
    MODE_8R  = 2'd2,
    MODE_ALT = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   gate_inv;
    logic   gate_en;
    logic   tick_sel;
    logic   ext_sel;
    tmode_e mode;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/gtmr_sync.sv
module gtmr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gtmr_step.sv
module gtmr_step (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic gate_en,
  input  logic gate_inv,
  input  logic ext_sel,
  input  logic tick_sel,
  input  logic tick_pre,
  input  logic cnt_s,
  input  logic gate_s,
  output logic step,
  output logic fall
);

  logic cnt_prev;
  logic gate_ok;
  logic src_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_prev <= 1'b0;
    else        cnt_prev <= cnt_s;
  end

  assign fall = cnt_prev & ~cnt_s;

  always_comb begin
    gate_ok = !gate_en || (gate_s ^ gate_inv);
    if (ext_sel)       src_hit = fall;
    else if (tick_sel) src_hit = tick_pre;
    else               src_hit = 1'b1;
    step = run && gate_ok && src_hit;
  end

endmodule

// File: rtl/gtmr_count.sv
module gtmr_count
  import gtmr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PRE_BITS = 5
) (
  input  tmode_e        mode,
  input  logic          step,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic [DW-1:0] lo_n,
  output logic [DW-1:0] hi_n,
  output logic          wrap
);

  localparam int W13 = PRE_BITS + DW;
  localparam int W16 = 2 * DW;

  logic [W13:0] sum13;
  logic [W16:0] sum16;
  logic [DW:0]  sum8;

  always_comb begin
    sum13 = {1'b0, hi, lo[PRE_BITS-1:0]} + {{W13{1'b0}}, 1'b1};
    sum16 = {1'b0, hi, lo} + {{W16{1'b0}}, 1'b1};
    sum8  = {1'b0, lo} + {{DW{1'b0}}, 1'b1};

    lo_n = lo;
    hi_n = hi;
    wrap = 1'b0;

    if (step) begin
      unique case (mode)
        MODE_13: begin
          lo_n = {lo[DW-1:PRE_BITS], sum13[PRE_BITS-1:0]};
          hi_n = sum13[W13-1:PRE_BITS];
          wrap = sum13[W13];
        end
        MODE_8R: begin
          lo_n = sum8[DW] ? hi : sum8[DW-1:0];
          wrap = sum8[DW];
        end
        default: begin
          lo_n = sum16[DW-1:0];
          hi_n = sum16[W16-1:DW];
          wrap = sum16[W16];
        end
      endcase
    end
  end

endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gtmr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int PRE_BITS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          tick_pre,
  input  logic          cnt_pin,
  input  logic          gate_pin,
  input  logic          irq_ack,
  output logic          ovf_flag,
  output logic          irq
);

  logic [DW-1:0] lo_q, hi_q, lo_n, hi_n;
  cfg_t          cfg_q;
  logic          run_q, ien_q, flag_q;
  logic          cnt_s, gate_s;
  logic          step, fall, step_go, wrap;
  logic          wr_lo, wr_hi, wr_cfg, wr_ctl;

  assign wr_lo  = wr_en && (wr_addr == A_LO);
  assign wr_hi  = wr_en && (wr_addr == A_HI);
  assign wr_cfg = wr_en && (wr_addr == A_CFG);
  assign wr_ctl = wr_en && (wr_addr == A_CTL);

  gtmr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cnt_pin, gate_pin}),
    .q     ({cnt_s, gate_s})
  );

  gtmr_step u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .gate_en  (cfg_q.gate_en),
    .gate_inv (cfg_q.gate_inv),
    .ext_sel  (cfg_q.ext_sel),
    .tick_sel (cfg_q.tick_sel),
    .tick_pre (tick_pre),
    .cnt_s    (cnt_s),
    .gate_s   (gate_s),
    .step     (step),
    .fall     (fall)
  );

  assign step_go = step && !wr_lo && !wr_hi;

  gtmr_count #(.DW(DW), .PRE_BITS(PRE_BITS)) u_count (
    .mode (cfg_q.mode),
    .step (step_go),
    .lo   (lo_q),
    .hi   (hi_q),
    .lo_n (lo_n),
    .hi_n (hi_n),
    .wrap (wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      cfg_q  <= '0;
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      lo_q <= wr_lo ? wr_data : lo_n;
      hi_q <= wr_hi ? wr_data : hi_n;
      if (wr_cfg) cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
      if (wr_ctl) begin
        run_q <= wr_data[CTL_RUN];
        ien_q <= wr_data[CTL_IEN];
      end
      if (wrap)
        flag_q <= 1'b1;
      else if (irq_ack || (wr_ctl && !wr_data[CTL_FLAG]))
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_LO:    rd_data = lo_q;
      A_HI:    rd_data = hi_q;
      A_CFG:   rd_data = {{(DW-CFG_W){1'b0}}, cfg_q};
      default: rd_data = {{(DW-3){1'b0}}, flag_q, ien_q, run_q};
    endcase
  end

  assign ovf_flag = flag_q;
  assign irq      = flag_q && ien_q;

endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker #(
  parameter int DW       = 8,
  parameter int PRE_BITS = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    mode,
  input logic          run,
  input logic          ext_sel,
  input logic          step,
  input logic          fall,
  input logic          wrap,
  input logic          flag,
  input logic          irq_ack,
  input logic          irq,
  input logic [DW-1:0] lo,
  input logic [DW-1:0] hi
);

  // R7: idle timer keeps its count
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable({hi, lo}));

  // R3: mode 0 leaves the upper low-byte bits alone
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !wr_en) |=> $stable(lo[DW-1:PRE_BITS]));

  // R4: reload byte is never changed by counting
  a_r4_reload_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !wr_en) |=> $stable(hi));

  // R6: external mode steps only on a detected falling edge
  a_r6_pin_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && step) |-> fall);

  // R10: an overflow always leaves the flag set
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);

  // R10: acknowledge clears the flag when no overflow competes
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !wrap) |=> !flag);

  // R9: no request without the flag
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

endmodule

bind gated_timer gtmr_checker #(.DW(DW), .PRE_BITS(PRE_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .mode    (cfg_q.mode),
  .run     (run_q),
  .ext_sel (cfg_q.ext_sel),
  .step    (step),
  .fall    (fall),
  .wrap    (wrap),
  .flag    (flag_q),
  .irq_ack (irq_ack),
  .irq     (irq),
  .lo      (lo_q),
  .hi      (hi_q)
);

// File: tb/gated_timer_test.sv
`timescale 1ns/1ps
module gated_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tick_pre = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       gate_pin = 1'b0;
  logic       irq_ack = 1'b0;
  logic       ovf_flag, irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gated_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_pre(tick_pre), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .irq_ack(irq_ack), .ovf_flag(ovf_flag), .irq(irq)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] n;
    logic [7:0] ehi;
    logic [7:0] elo;
    logic       ef;
  } vec_t;

  // counts taken = n + 1
  localparam vec_t VECS [7] = '{
    '{2'd1, 8'h00, 8'h00, 8'd9, 8'h00, 8'h0A, 1'b0},
    '{2'd1, 8'h00, 8'hFE, 8'd2, 8'h01, 8'h01, 1'b0},
    '{2'd1, 8'hFF, 8'hFE, 8'd2, 8'h00, 8'h01, 1'b1},
    '{2'd0, 8'h00, 8'h1E, 8'd2, 8'h01, 8'h01, 1'b0},
    '{2'd0, 8'hFF, 8'hFD, 8'd3, 8'h00, 8'hE1, 1'b1},
    '{2'd2, 8'hF0, 8'hFD, 8'd4, 8'hF0, 8'hF2, 1'b1},
    '{2'd2, 8'h00, 8'h10, 8'd4, 8'h00, 8'h15, 1'b0}
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic run_for(input int n);
    wr(2'd3, 8'h01);
    repeat (n) @(negedge clk);
    wr(2'd3, 8'h04);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reg", v, 8'h00);
    end
    chk("R1 flag", {7'd0, ovf_flag}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // table of mode scenarios (R2, R3, R4)
    for (int i = 0; i < 7; i++) begin
      string tag;
      tag = (VECS[i].mode == 2'd0) ? "R3" : (VECS[i].mode == 2'd2) ? "R4" : "R2";
      wr(2'd2, {6'd0, VECS[i].mode});
      wr(2'd0, VECS[i].lo);
      wr(2'd1, VECS[i].hi);
      run_for(int'(VECS[i].n));
      rd(2'd0, v); chk({tag, " low"}, v, VECS[i].elo);
      rd(2'd1, v); chk({tag, " high"}, v, VECS[i].ehi);
      chk({tag, " flag"}, {7'd0, ovf_flag}, {7'd0, VECS[i].ef});
    end

    // R5 prescaled ticks
    wr(2'd2, 8'h09); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd3, 8'h01);
    for (int k = 0; k < 3; k++) begin
      tick_pre = 1'b1; @(negedge clk); tick_pre = 1'b0;
      repeat (2) @(negedge clk);
    end
    wr(2'd3, 8'h04);
    rd(2'd0, v); chk("R5 tick count", v, 8'h03);

    // R6 external pin falling edges
    wr(2'd2, 8'h05); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd3, 8'h01);
    for (int k = 0; k < 3; k++) begin
      cnt_pin = 1'b0; tick_pre = 1'b1; repeat (4) @(negedge clk);
      cnt_pin = 1'b1; tick_pre = 1'b0; repeat (4) @(negedge clk);
    end
    wr(2'd3, 8'h04);
    rd(2'd0, v); chk("R6 edge count", v, 8'h03);

    // R7 run bit low
    wr(2'd2, 8'h01); wr(2'd0, 8'h05); wr(2'd3, 8'h04);
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R7 held", v, 8'h05);

    // R8 gate, active high
    wr(2'd2, 8'h11); gate_pin = 1'b0; repeat (4) @(negedge clk);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    run_for(5);
    rd(2'd0, v); chk("R8 gate low blocks", v, 8'h00);
    gate_pin = 1'b1; repeat (4) @(negedge clk);
    run_for(5);
    rd(2'd0, v); chk("R8 gate high counts", v, 8'h06);
    // R8 gate, inverted
    wr(2'd2, 8'h31); wr(2'd0, 8'h00); repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R8 cfg readback", v, 8'h31);
    run_for(5);
    rd(2'd0, v); chk("R8 inverted high blocks", v, 8'h00);
    gate_pin = 1'b0; repeat (4) @(negedge clk);
    run_for(5);
    rd(2'd0, v); chk("R8 inverted low counts", v, 8'h06);

    // R9 / R10 request and clears
    wr(2'd2, 8'h01); wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    wr(2'd3, 8'h03);
    wr(2'd3, 8'h06);
    chk("R9 irq with enable", {7'd0, irq}, 8'h01);
    rd(2'd3, v); chk("R10 ctl keep", v, 8'h06);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R10 ack clears", {7'd0, ovf_flag}, 8'h00);
    chk("R9 irq drops", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    run_for(0);
    chk("R9 flag set", {7'd0, ovf_flag}, 8'h01);
    chk("R9 no irq when disabled", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h02);
    chk("R10 write clears", {7'd0, ovf_flag}, 8'h00);

    // R10 set wins over clear (mode 2, reload 0xFF wraps each step)
    wr(2'd2, 8'h02); wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    wr(2'd3, 8'h01);
    wr(2'd3, 8'h01);
    chk("R10 set beats write clear", {7'd0, ovf_flag}, 8'h01);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R10 set beats ack", {7'd0, ovf_flag}, 8'h01);
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h00);
    chk("R10 cleared when idle", {7'd0, ovf_flag}, 8'h00);
    rd(2'd1, v); chk("R4 reload byte kept", v, 8'hFF);

    // R11 write overrides running count
    wr(2'd2, 8'h01); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd3, 8'h01);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h40);
    wr(2'd3, 8'h04);
    rd(2'd0, v); chk("R11 low after write", v, 8'h41);
    rd(2'd1, v); chk("R11 high after write", v, 8'h00);

    finish_run();
  end

endmodule